// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block makes the base timing for serial ports from the main clock. It does not produce a derived clock. It emits a one-cycle enable pulse, `baud_tick`, in the main clock domain. A serial port counts these pulses to time its bits. Two stages in series produce the pulse. The first is a coarse integer prescaler that divides the main clock by an 8-bit value `int_div`. The second is an optional fractional stage that swallows some of the prescaler's pulses. With the fractional stage on, the pulse rate is the prescaled rate × 256 / (256 + `frac_mult`).

The fractional stage is an 8-bit phase accumulator. It adds `frac_mult` for every pulse it lets through. When the addition carries out of 8 bits, the next prescaler pulse is dropped. Over any 256 pulses that reach the output, exactly `frac_mult` prescaler pulses are removed. The stage works only when `frac_mode` holds the enable code 0xFF; any other code bypasses it. A clear input, `frac_clr`, is held while new multiplier values are set up, so that the accumulator restarts from zero.

The prescaler has two states. IDLE leaves on *start* (a non-zero `int_div` is seen) for COUNT. COUNT stays there on *reload* (terminal count with a non-zero `int_div`) and returns to IDLE on *halt* (terminal count with `int_div` = 0). The fractional stage has three states. BYPASS (mode code is not 0xFF) moves to PASS on *arm*. PASS moves to DROP on *carry* (the accumulator overflows on a passed pulse). DROP returns to PASS on *swallow* (the next prescaler pulse is removed) or on *clear* (`frac_clr`). Any state returns to BYPASS on *disarm*.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, `baud_tick` is 0, the prescaler is in IDLE and the accumulator is zero.
- R2: With `int_div` = N (1..255) held and the fractional stage bypassed, `baud_tick` pulses exactly once every N clock cycles. The first pulse comes N cycles after the clock edge that first samples N out of IDLE.
- R3: With `int_div` = 0, no further pulse is produced once the period in progress ends; the prescaler then rests in IDLE.
- R4: A new `int_div` value is taken only at the prescaler's terminal count. The period in progress completes at its old length, and the next period has the new length.
- R5: The fractional stage is active only when `frac_mode` equals 0xFF. With any other code (for example 0x00 or 0xFE), every prescaler pulse reaches `baud_tick`.
- R6: With the stage active, each passed pulse adds `frac_mult` to the 8-bit accumulator. A carry swallows the next prescaler pulse. Over 256 + `frac_mult` prescaler pulses, exactly 256 reach the output. This also holds for `frac_mult` = 255.
- R7: With the stage active and `frac_mult` = 0, `baud_tick` is identical to the bypassed output.
- R8: While `frac_clr` is 1, the accumulator is held at zero and no pulse is swallowed.
- R9: Each output pulse lasts one cycle and follows the prescaler's terminal count by one register stage. For N > 1, `baud_tick` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_div | input | 8 | Integer prescaler divisor; 0 stops the output |
| frac_mode | input | 8 | Fractional stage mode; 0xFF enables it, other codes bypass |
| frac_mult | input | 8 | Fractional multiplier added to the accumulator per passed pulse |
| frac_clr | input | 1 | Holds the fractional accumulator at zero |
| baud_tick | output | 1 | One-cycle enable pulse at the resulting baud base rate |

## Verification
The assertions check several local properties on every cycle. The prescaler count stays within 1..N. A terminal count either reloads the latched divisor from `int_div` or halts into IDLE. A dropped pulse is never followed by a second drop. A clear leaves the accumulator at zero, and a bypassed stage passes its input unchanged. Some behaviours need whole stimulus sequences, so only the bench scenarios show them. These are the exact pulse spacing, the old period finishing before a new divisor applies, the 256-out-of-256+M ratio over a long window, and the match between M = 0 and bypass. The bench covers them with a cycle-by-cycle reference model and with pulse counts over windows.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    // Integer prescaler states
    typedef enum logic {
        PS_IDLE,
        PS_COUNT
    } ps_state_e;

    // Fractional stage states
    typedef enum logic [1:0] {
        FS_BYPASS,
        FS_PASS,
        FS_DROP
    } fs_state_e;

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import frac_baud_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] CNT_ONE  = DIV_W'(1);
    localparam logic [DIV_W-1:0] CNT_ZERO = '0;

    ps_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] lim_q, lim_d;
    logic             at_term;

    assign at_term = (state_q == PS_COUNT) && (cnt_q == lim_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= CNT_ZERO;
            lim_q   <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        unique case (state_q)
            PS_IDLE: begin
                if (div_i != CNT_ZERO) begin        // start
                    state_d = PS_COUNT;
                    lim_d   = div_i;
                    cnt_d   = CNT_ONE;
                end
            end
            PS_COUNT: begin
                if (at_term) begin
                    if (div_i == CNT_ZERO) begin    // halt
                        state_d = PS_IDLE;
                        cnt_d   = CNT_ZERO;
                        lim_d   = CNT_ZERO;
                    end else begin                  // reload
                        lim_d = div_i;
                        cnt_d = CNT_ONE;
                    end
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            default: begin
                state_d = PS_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        tick_o = at_term;
    end

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_COUNT) |-> (cnt_q >= CNT_ONE && cnt_q <= lim_q));

    a_r4_reload_at_term: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != CNT_ZERO) |=> (cnt_q == CNT_ONE && lim_q == $past(div_i)));

    a_r3_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i == CNT_ZERO) |=> (state_q == PS_IDLE));

    a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && lim_q > CNT_ONE && div_i > CNT_ONE) |=> !tick_o);

endmodule

// File: rtl/baud_frac_stage.sv
module baud_frac_stage
    import frac_baud_pkg::*;
#(
    parameter int              MULT_W      = 8,
    parameter int              MODE_W      = 8,
    parameter logic [MODE_W-1:0] ENABLE_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic              clr_i,
    output logic              pass_o
);

    localparam int SUM_W = MULT_W + 1;

    fs_state_e         state_q, state_d;
    logic [MULT_W-1:0] acc_q, acc_d;
    logic [SUM_W-1:0]  sum;
    logic              en;

    assign en  = (mode_i == ENABLE_CODE);
    assign sum = {1'b0, acc_q} + {1'b0, mult_i};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_BYPASS;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        if (!en) begin                              // disarm
            state_d = FS_BYPASS;
            acc_d   = '0;
        end else if (clr_i) begin                   // clear
            state_d = FS_PASS;
            acc_d   = '0;
        end else begin
            unique case (state_q)
                FS_BYPASS, FS_PASS: begin
                    if (tick_i) begin
                        acc_d   = sum[MULT_W-1:0];
                        state_d = sum[MULT_W] ? FS_DROP : FS_PASS;  // carry
                    end else begin
                        state_d = FS_PASS;          // arm
                    end
                end
                FS_DROP: begin
                    if (tick_i) state_d = FS_PASS;  // swallow
                end
                default: state_d = FS_BYPASS;
            endcase
        end
    end

    // outputs
    always_comb begin
        pass_o = tick_i && !(en && !clr_i && state_q == FS_DROP);
    end

    a_r5_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pass_o == tick_i));

    a_r6_single_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_DROP && tick_i && en && !clr_i) |=> (state_q != FS_DROP));

    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_q == '0));

    a_r7_zero_mult_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mult_i == '0 && state_q != FS_DROP) |=> (state_q != FS_DROP));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int DIV_W  = 8,
    parameter int MULT_W = 8,
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  int_div,
    input  logic [MODE_W-1:0] frac_mode,
    input  logic [MULT_W-1:0] frac_mult,
    input  logic              frac_clr,
    output logic              baud_tick
);

    localparam logic [MODE_W-1:0] FRAC_ON = '1;

    logic pre_tick;
    logic frac_pass;
    logic tick_q;

    baud_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (int_div),
        .tick_o (pre_tick)
    );

    baud_frac_stage #(
        .MULT_W      (MULT_W),
        .MODE_W      (MODE_W),
        .ENABLE_CODE (FRAC_ON)
    ) u_frac (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (pre_tick),
        .mode_i (frac_mode),
        .mult_i (frac_mult),
        .clr_i  (frac_clr),
        .pass_o (frac_pass)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= frac_pass;
    end

    assign baud_tick = tick_q;

    a_r9_follows_term: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(pre_tick));

    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!baud_tick || rst_n));

endmodule

// File: tb/tb_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_frac_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] int_div = 8'd0;
    logic [7:0] frac_mode = 8'd0;
    logic [7:0] frac_mult = 8'd0;
    logic       frac_clr = 1'b0;
    logic       baud_tick;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit started = 0;
    string cur_req = "R1";

    // reference model state
    bit m_run = 0;
    int m_lim = 0, m_cnt = 0, m_acc = 0;
    bit m_drop = 0, m_out = 0;

    always #2 clk = ~clk;

    frac_baud_gen dut (
        .clk(clk), .rst_n(rst_n), .int_div(int_div), .frac_mode(frac_mode),
        .frac_mult(frac_mult), .frac_clr(frac_clr), .baud_tick(baud_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference, stepped at every rising edge
    always @(posedge clk) begin
        bit itk, en, pass;
        cyc++;
        started = 1;
        if (!rst_n) begin
            m_run = 0; m_lim = 0; m_cnt = 0; m_acc = 0; m_drop = 0; m_out = 0;
        end else begin
            itk  = m_run && (m_cnt == m_lim);
            en   = (frac_mode == 8'hFF);
            pass = itk && !(en && !frac_clr && m_drop);
            m_out = pass;
            if (!en || frac_clr) begin
                m_acc = 0; m_drop = 0;
            end else if (itk) begin
                if (m_drop) m_drop = 0;
                else begin
                    m_acc = m_acc + frac_mult;
                    if (m_acc >= 256) begin m_acc = m_acc - 256; m_drop = 1; end
                end
            end
            if (!m_run) begin
                if (int_div != 0) begin m_run = 1; m_lim = int_div; m_cnt = 1; end
            end else if (itk) begin
                if (int_div == 0) m_run = 0;
                else begin m_lim = int_div; m_cnt = 1; end
            end else m_cnt++;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (started) check(baud_tick === m_out, cur_req, int'(baud_tick), int'(m_out));
    end

    task automatic count_win(input int n, output int c, output int pairs);
        bit prev = 0;
        c = 0; pairs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (baud_tick) c++;
            if (baud_tick && prev) pairs++;
            prev = baud_tick;
        end
    endtask

    task automatic wait_pulse(output int t);
        do @(negedge clk); while (!baud_tick);
        t = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c, pr, t0, t1, t2;
        // R1: reset
        repeat (3) @(negedge clk);
        check(baud_tick == 1'b0, "R1", int'(baud_tick), 0);
        @(negedge clk) rst_n = 1'b1;

        // R2: bypassed divide-by-5, then first pulse timing
        cur_req = "R2";
        @(negedge clk) int_div = 8'd5;
        count_win(30, c, pr);
        count_win(500, c, pr);
        check(c == 100, "R2", c, 100);

        // R9: divide-by-2 never back to back; divide-by-1 always high
        cur_req = "R9";
        @(negedge clk) int_div = 8'd2;
        count_win(20, c, pr);
        count_win(200, c, pr);
        check(pr == 0, "R9", pr, 0);
        check(c == 100, "R9", c, 100);
        @(negedge clk) int_div = 8'd1;
        count_win(10, c, pr);
        count_win(100, c, pr);
        check(c == 100, "R9", c, 100);

        // R4: change takes effect at terminal count
        cur_req = "R4";
        @(negedge clk) int_div = 8'd4;
        count_win(20, c, pr);
        wait_pulse(t0);
        @(negedge clk) int_div = 8'd7;
        wait_pulse(t1);
        wait_pulse(t2);
        check(t1 - t0 == 4, "R4", t1 - t0, 4);
        check(t2 - t1 == 7, "R4", t2 - t1, 7);

        // R3: divisor zero stops output
        cur_req = "R3";
        @(negedge clk) int_div = 8'd0;
        count_win(20, c, pr);
        count_win(200, c, pr);
        check(c == 0, "R3", c, 0);

        // R5: non-enable mode codes bypass
        cur_req = "R5";
        @(negedge clk) begin int_div = 8'd5; frac_mode = 8'h00; frac_mult = 8'd128; end
        count_win(30, c, pr);
        count_win(500, c, pr);
        check(c == 100, "R5", c, 100);
        @(negedge clk) frac_mode = 8'hFE;
        count_win(10, c, pr);
        count_win(500, c, pr);
        check(c == 100, "R5", c, 100);

        // R7: enabled with zero multiplier equals bypass
        cur_req = "R7";
        @(negedge clk) begin int_div = 8'd3; frac_mode = 8'hFF; frac_mult = 8'd0; end
        count_win(20, c, pr);
        count_win(300, c, pr);
        check(c == 100, "R7", c, 100);

        // R6: multiplier 64, 320 input pulses give 256 outputs
        cur_req = "R6";
        @(negedge clk) begin int_div = 8'd1; frac_mult = 8'd64; frac_clr = 1'b1; end
        repeat (2) @(negedge clk);
        frac_clr = 1'b0;
        count_win(5, c, pr);
        count_win(320, c, pr);
        check(c == 256, "R6", c, 256);
        // R6: multiplier 255, 511 input pulses give 256 outputs
        @(negedge clk) begin frac_mult = 8'd255; frac_clr = 1'b1; end
        @(negedge clk) frac_clr = 1'b0;
        count_win(7, c, pr);
        count_win(511, c, pr);
        check(c == 256, "R6", c, 256);
        // R6: coarse divide-by-3 with multiplier 128, 384 inputs -> 256 outputs
        @(negedge clk) begin int_div = 8'd3; frac_mult = 8'd128; end
        count_win(40, c, pr);
        count_win(1152, c, pr);
        check(c == 256, "R6", c, 256);

        // R8: clear held suppresses all drops
        cur_req = "R8";
        @(negedge clk) begin int_div = 8'd1; frac_clr = 1'b1; end
        count_win(10, c, pr);
        count_win(100, c, pr);
        check(c == 100, "R8", c, 100);
        @(negedge clk) frac_clr = 1'b0;

        // R1: reset mid-run returns output low
        cur_req = "R1";
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check(baud_tick == 1'b0, "R1", int'(baud_tick), 0);
        @(negedge clk) rst_n = 1'b1;
        count_win(20, c, pr);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule